// File: doc/BRIEF.md
# Stereo First-Order IIR Stream Filter

This block filters a stereo audio stream one frame at a time. Each 32-bit input beat holds one left and one right signed Q1.15 sample. The block splits the beat, runs each half through its own first-order recursive filter channel, and packs the two results back into one output beat. Both channels work in lockstep and use one shared coefficient set. The output beat is registered, so every result leaves exactly one clock after its input beat is accepted.

Each channel computes `y[n] = sat16((c0*x[n] + c1*x[n-1] + fb*y[n-1]) >>> 15)`. The products are full-width signed values and the sum is kept in a wider accumulator. The right shift is arithmetic, so it rounds toward minus infinity. `sat16` clamps the result to the range 0x8000..0x7FFF. The saturated output becomes the stored `y[n-1]` for the next beat.

An AXI4-Lite slave holds the settings: a control word with a filter-enable bit and a self-clearing history-clear bit, plus the three coefficients. Both stream sides follow valid/ready rules. The input accepts a beat only while the output register is empty or the output is being drained in the same cycle. This gives one beat per clock when the consumer is always ready. When the consumer holds ready low, the output beat stays stable and the input back-pressures.

Top module: `stereo_iir_stream`

## Requirements
- R1: After reset the output valid is low, the input ready is high, and every register reads zero. In particular the enable bit is 0.
- R2: Input bits [31:16] are the left sample and bits [15:0] are the right sample. Output results are packed in the same positions.
- R3: A beat accepted at clock edge k appears on the output, with output valid high, right after edge k.
- R4: Input ready equals (not output valid) or output ready. While output valid is high and output ready is low, the output data and last flag do not change.
- R5: The last flag of each accepted beat leaves together with that beat's data.
- R6: While enable (control bit 0) is 0, accepted beats pass to the output unchanged with the same latency. Both channels' histories stay frozen, so filtering resumes from the earlier history when enable returns to 1.
- R7: While enabled, each channel output follows the filter equation above, including the floor shift and the saturation to 0x8000..0x7FFF.
- R8: Both channels use the same coefficients. Each channel keeps its own history.
- R9: Register offsets are: control at 0x00, c0 at 0x04, c1 at 0x08, fb at 0x0C. A coefficient occupies bits [15:0], and bits [31:16] read as 0. A control read returns the enable bit in bit 0 and zeros elsewhere.
- R10: Writes honor the byte strobes. Strobe bit b enables data bits [8b+7:8b], and bytes whose strobe is 0 keep their old value.
- R11: Writing 1 to control bit 1 (with byte strobe 0 set) clears both channels' histories in the next cycle. The bit always reads as 0.
- R12: Reads of offsets 0x10..0x1C return 0. Writes to those offsets change nothing. Every response code is OKAY (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_axis_tdata | input | 32 | Input stereo beat |
| s_axis_tvalid | input | 1 | Input beat valid |
| s_axis_tready | output | 1 | Input ready |
| s_axis_tlast | input | 1 | Input packet end |
| m_axis_tdata | output | 32 | Output stereo beat |
| m_axis_tvalid | output | 1 | Output beat valid |
| m_axis_tready | input | 1 | Output ready |
| m_axis_tlast | output | 1 | Output packet end |
| s_axil_awaddr | input | 5 | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | 32 | Write data |
| s_axil_wstrb | input | 4 | Write byte strobes |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | 5 | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | 32 | Read data |
| s_axil_rresp | output | 2 | Read response |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |

## Verification
A beat accepted at an edge is checked at the falling edge that follows it, where its filtered or passed-through value and last flag must already be present. A register write takes effect at the edge where the address and data are both accepted. A clear request zeroes the histories one edge later, so the bench waits two further cycles before sending the next beat. Read data is sampled at the falling edge after the address handshake. Under back-pressure the held beat is sampled on several successive falling edges, and the queued beat is checked one cycle after output ready returns.

// File: rtl/stereo_iir_pkg.sv
package stereo_iir_pkg;
  localparam int LITE_DW = 32;
  localparam int LITE_SW = LITE_DW / 8;

  typedef enum logic [1:0] {
    RIDX_CTRL = 2'd0,
    RIDX_C0   = 2'd1,
    RIDX_C1   = 2'd2,
    RIDX_FB   = 2'd3
  } reg_idx_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;
endpackage

// File: rtl/iir_channel.sv
module iir_channel #(
  parameter int SAMPLE_W = 16,
  parameter int FRAC_W   = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       upd,
  input  logic signed [SAMPLE_W-1:0] x_in,
  input  logic signed [SAMPLE_W-1:0] c0,
  input  logic signed [SAMPLE_W-1:0] c1,
  input  logic signed [SAMPLE_W-1:0] fb,
  output logic signed [SAMPLE_W-1:0] y_out
);
  localparam int PROD_W = 2 * SAMPLE_W;
  localparam int ACC_W  = PROD_W + 2;
  localparam logic signed [ACC_W-1:0] SAT_HI =
    {{(ACC_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO =
    {{(ACC_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

  logic signed [SAMPLE_W-1:0] x_q, y_q;
  logic signed [PROD_W-1:0]   p_ff0, p_ff1, p_fb;
  logic signed [ACC_W-1:0]    acc, shifted;

  always_comb begin
    p_ff0   = c0 * x_in;
    p_ff1   = c1 * x_q;
    p_fb    = fb * y_q;
    acc     = ACC_W'(p_ff0) + ACC_W'(p_ff1) + ACC_W'(p_fb);
    shifted = acc >>> FRAC_W;
    if (shifted > SAT_HI)      y_out = SAT_HI[SAMPLE_W-1:0];
    else if (shifted < SAT_LO) y_out = SAT_LO[SAMPLE_W-1:0];
    else                       y_out = shifted[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      x_q <= '0;
      y_q <= '0;
    end else if (upd) begin
      x_q <= x_in;
      y_q <= y_out;
    end
  end

  // R11: a clear request leaves an empty history behind it
  a_r11_clear_history: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (x_q == '0 && y_q == '0));
  // R6: without an update or clear, history is frozen
  a_r6_history_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> ($stable(x_q) && $stable(y_q)));
  // R7: saturated output always within range (sign bit agrees with range)
  a_r7_output_range: assert property (@(posedge clk) disable iff (!rst_n)
    (shifted > SAT_HI) |-> (y_out == SAT_HI[SAMPLE_W-1:0]));
endmodule

// File: rtl/stereo_iir_regs.sv
module stereo_iir_regs
  import stereo_iir_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                awvalid,
  output logic                awready,
  input  logic [LITE_DW-1:0]  wdata,
  input  logic [LITE_SW-1:0]  wstrb,
  input  logic                wvalid,
  output logic                wready,
  output logic [1:0]          bresp,
  output logic                bvalid,
  input  logic                bready,
  input  logic [ADDR_W-1:0]   araddr,
  input  logic                arvalid,
  output logic                arready,
  output logic [LITE_DW-1:0]  rdata,
  output logic [1:0]          rresp,
  output logic                rvalid,
  input  logic                rready,
  output logic                enable,
  output logic                clr_pulse,
  output logic [SAMPLE_W-1:0] c0,
  output logic [SAMPLE_W-1:0] c1,
  output logic [SAMPLE_W-1:0] fb
);
  localparam int IDX_W = ADDR_W - 2;

  logic             wr_go, rd_go;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             wr_mapped, rd_mapped;
  logic [LITE_DW-1:0] rd_word;

  assign awready = awvalid && wvalid && !bvalid;
  assign wready  = awready;
  assign wr_go   = awready;
  assign arready = !rvalid;
  assign rd_go   = arvalid && arready;
  assign bresp   = RESP_OKAY;
  assign rresp   = RESP_OKAY;

  assign wr_idx    = awaddr[ADDR_W-1:2];
  assign rd_idx    = araddr[ADDR_W-1:2];
  assign wr_mapped = (wr_idx >> 2) == '0;
  assign rd_mapped = (rd_idx >> 2) == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable    <= 1'b0;
      clr_pulse <= 1'b0;
      c0        <= '0;
      c1        <= '0;
      fb        <= '0;
    end else begin
      clr_pulse <= 1'b0;
      if (wr_go && wr_mapped) begin
        unique case (reg_idx_e'(wr_idx[1:0]))
          RIDX_CTRL: if (wstrb[0]) begin
            enable    <= wdata[CTRL_EN_BIT];
            clr_pulse <= wdata[CTRL_CLR_BIT];
          end
          RIDX_C0: for (int i = 0; i < SAMPLE_W; i++)
            if (wstrb[i/8]) c0[i] <= wdata[i];
          RIDX_C1: for (int i = 0; i < SAMPLE_W; i++)
            if (wstrb[i/8]) c1[i] <= wdata[i];
          RIDX_FB: for (int i = 0; i < SAMPLE_W; i++)
            if (wstrb[i/8]) fb[i] <= wdata[i];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bvalid <= 1'b0;
    else if (wr_go) bvalid <= 1'b1;
    else if (bready) bvalid <= 1'b0;
  end

  always_comb begin
    rd_word = '0;
    if (rd_mapped) begin
      unique case (reg_idx_e'(rd_idx[1:0]))
        RIDX_CTRL: rd_word[CTRL_EN_BIT] = enable;
        RIDX_C0:   rd_word[SAMPLE_W-1:0] = c0;
        RIDX_C1:   rd_word[SAMPLE_W-1:0] = c1;
        RIDX_FB:   rd_word[SAMPLE_W-1:0] = fb;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (rd_go) begin
      rvalid <= 1'b1;
      rdata  <= rd_word;
    end else if (rready) begin
      rvalid <= 1'b0;
    end
  end

  // R12: write response held until taken
  a_r12_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);
  // R9: read data held stable until taken
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
  // R11: clear request lasts a single cycle
  a_r11_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);
endmodule

// File: rtl/stereo_iir_stream.sv
module stereo_iir_stream
  import stereo_iir_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int FRAC_W   = 15,
  parameter int ADDR_W   = 5,
  localparam int BEAT_W  = 2 * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BEAT_W-1:0] s_axis_tdata,
  input  logic              s_axis_tvalid,
  output logic              s_axis_tready,
  input  logic              s_axis_tlast,
  output logic [BEAT_W-1:0] m_axis_tdata,
  output logic              m_axis_tvalid,
  input  logic              m_axis_tready,
  output logic              m_axis_tlast,
  input  logic [ADDR_W-1:0] s_axil_awaddr,
  input  logic              s_axil_awvalid,
  output logic              s_axil_awready,
  input  logic [31:0]       s_axil_wdata,
  input  logic [3:0]        s_axil_wstrb,
  input  logic              s_axil_wvalid,
  output logic              s_axil_wready,
  output logic [1:0]        s_axil_bresp,
  output logic              s_axil_bvalid,
  input  logic              s_axil_bready,
  input  logic [ADDR_W-1:0] s_axil_araddr,
  input  logic              s_axil_arvalid,
  output logic              s_axil_arready,
  output logic [31:0]       s_axil_rdata,
  output logic [1:0]        s_axil_rresp,
  output logic              s_axil_rvalid,
  input  logic              s_axil_rready
);
  localparam int N_CH = 2;

  logic                enable, clr_pulse, accept, upd;
  logic [SAMPLE_W-1:0] c0, c1, fb;
  logic [BEAT_W-1:0]   filtered;

  stereo_iir_regs #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_axil_awaddr), .awvalid(s_axil_awvalid), .awready(s_axil_awready),
    .wdata(s_axil_wdata), .wstrb(s_axil_wstrb), .wvalid(s_axil_wvalid),
    .wready(s_axil_wready), .bresp(s_axil_bresp), .bvalid(s_axil_bvalid),
    .bready(s_axil_bready), .araddr(s_axil_araddr), .arvalid(s_axil_arvalid),
    .arready(s_axil_arready), .rdata(s_axil_rdata), .rresp(s_axil_rresp),
    .rvalid(s_axil_rvalid), .rready(s_axil_rready),
    .enable(enable), .clr_pulse(clr_pulse), .c0(c0), .c1(c1), .fb(fb)
  );

  assign s_axis_tready = !m_axis_tvalid || m_axis_tready;
  assign accept        = s_axis_tvalid && s_axis_tready;
  assign upd           = accept && enable;

  // channel 0 is right (low half), channel 1 is left (high half)
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic signed [SAMPLE_W-1:0] y_ch;
    iir_channel #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W)) i_ch (
      .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .upd(upd),
      .x_in(s_axis_tdata[g*SAMPLE_W +: SAMPLE_W]),
      .c0(c0), .c1(c1), .fb(fb), .y_out(y_ch)
    );
    assign filtered[g*SAMPLE_W +: SAMPLE_W] = y_ch;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_axis_tvalid <= 1'b0;
      m_axis_tdata  <= '0;
      m_axis_tlast  <= 1'b0;
    end else if (accept) begin
      m_axis_tvalid <= 1'b1;
      m_axis_tdata  <= enable ? filtered : s_axis_tdata;
      m_axis_tlast  <= s_axis_tlast;
    end else if (m_axis_tready) begin
      m_axis_tvalid <= 1'b0;
    end
  end

  // R3, R5: accepted beat is on the output one edge later with its last flag
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (m_axis_tvalid && m_axis_tlast == $past(s_axis_tlast)));
  // R4: output beat held under back-pressure
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_axis_tvalid && !m_axis_tready) |=>
      (m_axis_tvalid && $stable(m_axis_tdata) && $stable(m_axis_tlast)));
  // R6: bypassed beat emerges unchanged
  a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !enable) |=> (m_axis_tdata == $past(s_axis_tdata)));
endmodule

// File: tb/test_stereo_iir_stream.sv
module test_stereo_iir_stream;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] s_tdata = '0;
  logic s_tvalid = 0, s_tlast = 0, s_tready;
  logic [31:0] m_tdata;
  logic m_tvalid, m_tlast, m_tready = 1;
  logic [4:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, arvalid = 0, awready, wready, arready;
  logic [31:0] wdata = '0, rdata;
  logic [3:0] wstrb = '0;
  logic [1:0] bresp, rresp;
  logic bvalid, rvalid;

  stereo_iir_stream i_stereo_iir_stream (
    .clk(clk), .rst_n(rst_n),
    .s_axis_tdata(s_tdata), .s_axis_tvalid(s_tvalid), .s_axis_tready(s_tready),
    .s_axis_tlast(s_tlast), .m_axis_tdata(m_tdata), .m_axis_tvalid(m_tvalid),
    .m_axis_tready(m_tready), .m_axis_tlast(m_tlast),
    .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
    .s_axil_wdata(wdata), .s_axil_wstrb(wstrb), .s_axil_wvalid(wvalid),
    .s_axil_wready(wready), .s_axil_bresp(bresp), .s_axil_bvalid(bvalid),
    .s_axil_bready(1'b1), .s_axil_araddr(araddr), .s_axil_arvalid(arvalid),
    .s_axil_arready(arready), .s_axil_rdata(rdata), .s_axil_rresp(rresp),
    .s_axil_rvalid(rvalid), .s_axil_rready(1'b1)
  );

  int n_tests = 0, n_fail = 0;
  longint hl_x = 0, hl_y = 0, hr_x = 0, hr_y = 0;
  logic [15:0] k0 = '0, k1 = '0, kf = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic longint step(input logic [15:0] x, input longint xp, input longint yp);
    longint acc, sh;
    acc = longint'($signed(k0)) * longint'($signed(x)) +
          longint'($signed(k1)) * xp + longint'($signed(kf)) * yp;
    sh = acc >>> 15;
    if (sh > 32767) sh = 32767;
    if (sh < -32768) sh = -32768;
    return sh;
  endfunction

  task automatic lite_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    #1;
    while (!awready) begin @(negedge clk); #1; end
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk("R12 bresp", {30'd0, bresp}, 32'd0);
  endtask

  task automatic lite_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1;
    #1;
    while (!arready) begin @(negedge clk); #1; end
    @(negedge clk);
    arvalid = 0;
    d = rdata;
    chk("R12 rresp", {30'd0, rresp}, 32'd0);
  endtask

  task automatic send_beat(input logic [31:0] d, input logic l);
    @(negedge clk);
    s_tdata = d; s_tvalid = 1; s_tlast = l;
    #1;
    while (!s_tready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_tvalid = 0;
  endtask

  task automatic set_coeffs(input logic [15:0] a, input logic [15:0] b, input logic [15:0] f);
    lite_write(5'h04, {16'd0, a}, 4'hF);
    lite_write(5'h08, {16'd0, b}, 4'hF);
    lite_write(5'h0C, {16'd0, f}, 4'hF);
    k0 = a; k1 = b; kf = f;
  endtask

  task automatic clear_hist();
    lite_write(5'h00, 32'h3, 4'h1);
    hl_x = 0; hl_y = 0; hr_x = 0; hr_y = 0;
    @(negedge clk); @(negedge clk);
  endtask

  // sends one filtered beat and checks it against the model (R2, R3, R5, R7, R8)
  task automatic filt_beat(input logic [15:0] l, input logic [15:0] r, input logic last);
    longint yl, yr;
    yl = step(l, hl_x, hl_y);
    yr = step(r, hr_x, hr_y);
    send_beat({l, r}, last);
    chk("R3 valid", {31'd0, m_tvalid}, 32'd1);
    chk("R7 R8 R2 filtered", m_tdata, {16'(yl), 16'(yr)});
    chk("R5 last", {31'd0, m_tlast}, {31'd0, last});
    hl_x = longint'($signed(l)); hl_y = yl;
    hr_x = longint'($signed(r)); hr_y = yr;
  endtask

  function automatic logic [15:0] pat(input int i);
    case (i % 8)
      0: return 16'h7FFF; 1: return 16'h8000; 2: return 16'h0000; 3: return 16'h4000;
      4: return 16'hC000; 5: return 16'h0001; 6: return 16'hFFFF; default: return 16'h1234;
    endcase
  endfunction

  function automatic logic [15:0] cset(input int s, input int which);
    logic [15:0] t [0:5][0:2];
    t[0] = '{16'h7FFF, 16'h0000, 16'h0000};
    t[1] = '{16'h4000, 16'h4000, 16'h0000};
    t[2] = '{16'h1000, 16'h0000, 16'h7000};
    t[3] = '{16'h7FFF, 16'h7FFF, 16'h7FFF};
    t[4] = '{16'h8000, 16'h8000, 16'h8000};
    t[5] = '{16'h2345, 16'hE000, 16'hC123};
    return t[s][which];
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 m_tvalid", {31'd0, m_tvalid}, 32'd0);
    chk("R1 s_tready", {31'd0, s_tready}, 32'd1);
    for (int a = 0; a < 4; a++) begin
      lite_read(5'(a * 4), rd);
      chk("R1 reg zero", rd, 32'd0);
    end

    // R9, R10: map and byte strobes
    lite_write(5'h04, 32'h0000_1234, 4'hF);
    lite_write(5'h04, 32'h0000_AB00, 4'h2);
    lite_read(5'h04, rd);
    chk("R10 strobe byte1", rd, 32'h0000_AB34);
    lite_write(5'h04, 32'hFFFF_00CD, 4'hC);
    lite_read(5'h04, rd);
    chk("R9 R10 upper bytes", rd, 32'h0000_AB34);
    lite_write(5'h08, 32'h0000_5566, 4'hF);
    lite_write(5'h0C, 32'h0000_7788, 4'hF);
    lite_read(5'h08, rd); chk("R9 c1 offset", rd, 32'h0000_5566);
    lite_read(5'h0C, rd); chk("R9 fb offset", rd, 32'h0000_7788);
    lite_write(5'h00, 32'h1, 4'h0);
    lite_read(5'h00, rd); chk("R10 ctrl strobe off", rd, 32'd0);

    // R12: unmapped offsets
    lite_write(5'h14, 32'hFFFF_FFFF, 4'hF);
    lite_read(5'h14, rd); chk("R12 unmapped read", rd, 32'd0);
    lite_read(5'h1C, rd); chk("R12 unmapped read", rd, 32'd0);
    lite_read(5'h04, rd); chk("R12 write ignored", rd, 32'h0000_AB34);
    lite_read(5'h00, rd); chk("R12 write ignored ctrl", rd, 32'd0);

    // R6: bypass before enabling
    send_beat(32'hDEAD_BEEF, 1'b1);
    chk("R6 bypass data", m_tdata, 32'hDEAD_BEEF);
    chk("R5 bypass last", {31'd0, m_tlast}, 32'd1);

    // R7, R8: sweep coefficient sets over input patterns
    for (int s = 0; s < 6; s++) begin
      set_coeffs(cset(s, 0), cset(s, 1), cset(s, 2));
      clear_hist();
      lite_read(5'h00, rd);
      chk("R11 clr reads 0", rd, 32'd1);
      for (int i = 0; i < 8; i++)
        filt_beat(pat(i + s), pat(i + s + 3), i == 7);
    end

    // R6: disable, pass through, re-enable resumes history
    set_coeffs(16'h3000, 16'h2000, 16'h5000);
    clear_hist();
    filt_beat(16'h4000, 16'hA000, 1'b0);
    filt_beat(16'h1111, 16'h7000, 1'b0);
    lite_write(5'h00, 32'h0, 4'h1);
    for (int i = 0; i < 3; i++) begin
      send_beat({pat(i), pat(i + 4)}, 1'b0);
      chk("R6 passthrough", m_tdata, {pat(i), pat(i + 4)});
    end
    lite_write(5'h00, 32'h1, 4'h1);
    filt_beat(16'h2222, 16'hE000, 1'b1);

    // R11: clear empties history
    clear_hist();
    filt_beat(16'h0100, 16'hFF00, 1'b0);

    // R4: back-pressure
    lite_write(5'h00, 32'h0, 4'h1);
    @(negedge clk);
    m_tready = 0;
    s_tdata = 32'h1111_2222; s_tvalid = 1; s_tlast = 1;
    @(negedge clk);
    s_tdata = 32'h3333_4444; s_tlast = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R4 held data", m_tdata, 32'h1111_2222);
      chk("R4 held last", {31'd0, m_tlast}, 32'd1);
      chk("R4 ready low", {31'd0, s_tready}, 32'd0);
      @(negedge clk);
    end
    m_tready = 1;
    #1;
    chk("R4 ready follows", {31'd0, s_tready}, 32'd1);
    @(negedge clk);
    s_tvalid = 0;
    chk("R4 next beat", m_tdata, 32'h3333_4444);
    chk("R4 next last", {31'd0, m_tlast}, 32'd0);
    @(negedge clk);
    chk("R3 drained", {31'd0, m_tvalid}, 32'd0);

    finish_run();
  end
endmodule